// File: doc/BRIEF.md
# Floating-Point Status and Control Register

This block holds the 32-bit status and control word of a floating-point unit. Software reaches it through one atomic update port. Each update carries a mask word and a flags word, and the port returns the whole word as it stood before the update. Each software-writable bit becomes `(old AND NOT mask) XOR flags`. For each bit this gives four operations: keep, toggle, clear and set. The vector-control bits and the reserved bits are outside the reach of this port. The vector-control bits change only through a separate privileged load port, and the reserved bits always read as zero.

The arithmetic datapath reports events on per-cycle strobes, one for each of the five IEEE exceptions and one for SIMD integer saturation. For an exception whose trap enable is clear, the strobe sets a sticky flag, and only software ever clears that flag. For an exception whose trap enable is set, the strobe leaves the sticky flag alone. Instead the block raises a one-cycle trap request together with a vector of the trapped exceptions. The rounding-mode field and the flush-to-zero enable go straight out to the datapath.

Top module: `fp_status_ctrl`

## Requirements
- R1: After reset the word reads 0, `trap_req` is 0, `trap_vec` is 0, `round_mode` is 00 and `flush_zero` is 0.
- R2: An update with `upd_valid`=1 takes effect at the next rising edge. Each writable bit becomes (old & ~mask) ^ flags: mask 0 / flags 0 keeps the bit, mask 0 / flags 1 toggles it, mask 1 / flags 0 clears it, mask 1 / flags 1 sets it. The writable bits are 4:0, 12:8, 24:22 and 27.
- R3: While `upd_valid` is high, `prev_word` shows the full 32-bit word before the update is applied.
- R4: An update never changes bits 16-18 or 20-21. Every bit outside 4:0, 12:8, 18:16, 24:20 and 27 always reads 0.
- R5: Exception strobe bit i sets sticky bit i at the next edge when trap enable bit 8+i is 0. The order is invalid=0, divide-by-zero=1, overflow=2, underflow=3, inexact=4. Without an update, a sticky bit never falls.
- R6: An exception strobe bit i with trap enable bit 8+i equal to 1 leaves sticky bit i unchanged. After the next edge, `trap_req` is 1 for one cycle and `trap_vec` bit i is 1 (bit i of `trap_vec` matches exception i).
- R7: `round_mode` outputs bits 23:22 (00 nearest, 01 up, 10 down, 11 toward zero), and `flush_zero` outputs bit 24.
- R8: `sat_strobe` sets bit 27 at the next edge. Bit 27 stays set until an update clears it.
- R9: `vec_load` writes `vec_data[2:0]` into bits 18:16 and `vec_data[4:3]` into bits 21:20 at the next edge. No other source changes those bits.
- R10: When an update and exception strobes arrive in the same cycle, the update is applied first and the untrapped strobes are then ORed into the sticky bits. The trap decision uses the enables held before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| upd_valid | input | 1 | Software update request |
| upd_mask | input | 32 | Update mask word |
| upd_flags | input | 32 | Update flags word |
| prev_word | output | 32 | Word before any pending update |
| vec_load | input | 1 | Privileged load of the vector-control bits |
| vec_data | input | 5 | Vector-control value to load |
| exc_strobe | input | 5 | Per-cycle IEEE exception events |
| sat_strobe | input | 1 | Per-cycle SIMD saturation event |
| trap_req | output | 1 | Trap request, one cycle per trapping event |
| trap_vec | output | 5 | Trapped exceptions |
| round_mode | output | 2 | Rounding mode to the datapath |
| flush_zero | output | 1 | Flush-to-zero enable to the datapath |

## Verification
`prev_word` is combinational, so the prior value is checked in the same cycle as the update request, before the clock edge. Updates, vector loads, sticky sets and saturation all land on the word one edge later. Trap request and trap vector are registered, so they also appear one edge after the strobe and fall after the next edge. The bench drives every input on the falling edge and samples on the following falling edge, which puts every expected value exactly one rising edge after its stimulus.

// File: rtl/fpsc_pkg.sv
package fpsc_pkg;

   // contiguous field of w ones starting at bit lsb
   function automatic logic [63:0] field_mask(input int lsb, input int w);
      return ((64'd1 << w) - 64'd1) << lsb;
   endfunction

   // word position of vector-control bit i (split into low and high groups)
   function automatic int vec_bit_pos(input int i, input int lo_lsb, input int lo_w,
                                      input int hi_lsb);
      return (i < lo_w) ? (lo_lsb + i) : (hi_lsb + i - lo_w);
   endfunction

endpackage

// File: rtl/fpsc_update.sv
module fpsc_update #(
   parameter int                WORD_W  = 32,
   parameter logic [WORD_W-1:0] WR_MASK = '0
) (
   input  logic              upd_en,
   input  logic [WORD_W-1:0] cur,
   input  logic [WORD_W-1:0] mask,
   input  logic [WORD_W-1:0] flags,
   output logic [WORD_W-1:0] nxt
);

   logic [WORD_W-1:0] edited;

   always_comb begin
      edited = (cur & ~mask) ^ flags;
      nxt    = upd_en ? ((edited & WR_MASK) | (cur & ~WR_MASK)) : cur;
   end

endmodule

// File: rtl/fpsc_event.sv
module fpsc_event #(
   parameter int EXC_N    = 5,
   parameter bit REG_TRAP = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [EXC_N-1:0] exc,
   input  logic [EXC_N-1:0] trap_en,
   output logic [EXC_N-1:0] set_sticky,
   output logic             trap_req,
   output logic [EXC_N-1:0] trap_vec
);

   logic [EXC_N-1:0] hit;

   assign hit        = exc & trap_en;
   assign set_sticky = exc & ~trap_en;

   if (REG_TRAP) begin : g_reg
      logic [EXC_N-1:0] tv_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) tv_q <= '0;
         else        tv_q <= hit;
      end
      assign trap_vec = tv_q;
   end else begin : g_comb
      assign trap_vec = hit;
   end

   assign trap_req = |trap_vec;

endmodule

// File: rtl/fpsc_vec_place.sv
module fpsc_vec_place #(
   parameter int WORD_W = 32,
   parameter int LO_LSB = 16,
   parameter int LO_W   = 3,
   parameter int HI_LSB = 20,
   parameter int HI_W   = 2,
   localparam int VEC_W = LO_W + HI_W
) (
   input  logic [VEC_W-1:0]  data,
   output logic [WORD_W-1:0] placed
);

   always_comb begin
      placed = '0;
      for (int i = 0; i < VEC_W; i++)
         placed[fpsc_pkg::vec_bit_pos(i, LO_LSB, LO_W, HI_LSB)] = data[i];
   end

endmodule

// File: rtl/fp_status_ctrl.sv
module fp_status_ctrl #(
   parameter int WORD_W     = 32,
   parameter int EXC_N      = 5,
   parameter int STICKY_LSB = 0,
   parameter int TRAP_LSB   = 8,
   parameter int VEC_LO_LSB = 16,
   parameter int VEC_LO_W   = 3,
   parameter int VEC_HI_LSB = 20,
   parameter int VEC_HI_W   = 2,
   parameter int RM_LSB     = 22,
   parameter int FZ_POS     = 24,
   parameter int SAT_POS    = 27,
   parameter bit REG_TRAP   = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         upd_valid,
   input  logic [WORD_W-1:0]            upd_mask,
   input  logic [WORD_W-1:0]            upd_flags,
   output logic [WORD_W-1:0]            prev_word,
   input  logic                         vec_load,
   input  logic [VEC_LO_W+VEC_HI_W-1:0] vec_data,
   input  logic [EXC_N-1:0]             exc_strobe,
   input  logic                         sat_strobe,
   output logic                         trap_req,
   output logic [EXC_N-1:0]             trap_vec,
   output logic [1:0]                   round_mode,
   output logic                         flush_zero
);

   localparam logic [WORD_W-1:0] STK_M = WORD_W'(fpsc_pkg::field_mask(STICKY_LSB, EXC_N));
   localparam logic [WORD_W-1:0] TEN_M = WORD_W'(fpsc_pkg::field_mask(TRAP_LSB, EXC_N));
   localparam logic [WORD_W-1:0] RM_M  = WORD_W'(fpsc_pkg::field_mask(RM_LSB, 2));
   localparam logic [WORD_W-1:0] FZ_M  = WORD_W'(fpsc_pkg::field_mask(FZ_POS, 1));
   localparam logic [WORD_W-1:0] SAT_M = WORD_W'(fpsc_pkg::field_mask(SAT_POS, 1));
   localparam logic [WORD_W-1:0] VEC_M = WORD_W'(fpsc_pkg::field_mask(VEC_LO_LSB, VEC_LO_W))
                                       | WORD_W'(fpsc_pkg::field_mask(VEC_HI_LSB, VEC_HI_W));
   localparam logic [WORD_W-1:0] WR_M  = STK_M | TEN_M | RM_M | FZ_M | SAT_M;
   localparam logic [WORD_W-1:0] DEF_M = WR_M | VEC_M;
   localparam int FIELD_BITS = 2 * EXC_N + 2 + 1 + 1 + VEC_LO_W + VEC_HI_W;

   // elaboration-time parameter checks
   if (WORD_W > 64 || WORD_W < 8) begin : g_bad_width
      $error("fp_status_ctrl: WORD_W out of range");
   end
   if (SAT_POS >= WORD_W || FZ_POS >= WORD_W || RM_LSB + 2 > WORD_W
       || TRAP_LSB + EXC_N > WORD_W || VEC_HI_LSB + VEC_HI_W > WORD_W) begin : g_bad_fit
      $error("fp_status_ctrl: a field lies outside the word");
   end
   if ($countones(DEF_M) != FIELD_BITS) begin : g_bad_overlap
      $error("fp_status_ctrl: fields overlap");
   end

   logic [WORD_W-1:0] word_q;
   logic [WORD_W-1:0] upd_word;
   logic [WORD_W-1:0] vec_word;
   logic [WORD_W-1:0] set_word;
   logic [WORD_W-1:0] word_d;
   logic [EXC_N-1:0]  set_sticky;

   fpsc_update #(.WORD_W(WORD_W), .WR_MASK(WR_M)) u_upd (
      .upd_en (upd_valid),
      .cur    (word_q),
      .mask   (upd_mask),
      .flags  (upd_flags),
      .nxt    (upd_word)
   );

   fpsc_vec_place #(
      .WORD_W(WORD_W), .LO_LSB(VEC_LO_LSB), .LO_W(VEC_LO_W),
      .HI_LSB(VEC_HI_LSB), .HI_W(VEC_HI_W)
   ) u_vec (
      .data   (vec_data),
      .placed (vec_word)
   );

   fpsc_event #(.EXC_N(EXC_N), .REG_TRAP(REG_TRAP)) u_evt (
      .clk        (clk),
      .rst_n      (rst_n),
      .exc        (exc_strobe),
      .trap_en    (word_q[TRAP_LSB +: EXC_N]),
      .set_sticky (set_sticky),
      .trap_req   (trap_req),
      .trap_vec   (trap_vec)
   );

   always_comb begin
      set_word = (WORD_W'(set_sticky) << STICKY_LSB) | (WORD_W'(sat_strobe) << SAT_POS);
      word_d   = vec_load ? ((upd_word & ~VEC_M) | (vec_word & VEC_M)) : upd_word;
      word_d   = (word_d | set_word) & DEF_M;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q <= '0;
      else        word_q <= word_d;
   end

   assign prev_word  = word_q;
   assign round_mode = word_q[RM_LSB +: 2];
   assign flush_zero = word_q[FZ_POS];

endmodule

// File: rtl/fpsc_checker.sv
module fpsc_checker #(
   parameter int                WORD_W     = 32,
   parameter int                EXC_N      = 5,
   parameter int                STICKY_LSB = 0,
   parameter int                TRAP_LSB   = 8,
   parameter logic [WORD_W-1:0] VEC_M      = '0,
   parameter logic [WORD_W-1:0] DEF_M      = '0,
   parameter bit                REG_TRAP   = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              upd_valid,
   input logic              vec_load,
   input logic [EXC_N-1:0]  exc_strobe,
   input logic [EXC_N-1:0]  trap_vec,
   input logic [WORD_W-1:0] word
);

   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (word & ~DEF_M) == '0); // R4

   AST_VEC_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(vec_load) |-> ((word & VEC_M) == ($past(word) & VEC_M))); // R9

   AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(upd_valid) |->
         ((word[STICKY_LSB +: EXC_N] & $past(word[STICKY_LSB +: EXC_N]))
          == $past(word[STICKY_LSB +: EXC_N]))); // R5

   AST_TRAPPED_NO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(upd_valid) |->
         ((word[STICKY_LSB +: EXC_N] & ~$past(word[STICKY_LSB +: EXC_N])
           & $past(word[TRAP_LSB +: EXC_N])) == '0)); // R6

   if (REG_TRAP) begin : g_reg_chk
      AST_TRAP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
         trap_vec == ($past(exc_strobe) & $past(word[TRAP_LSB +: EXC_N]))); // R6
   end else begin : g_comb_chk
      AST_TRAP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
         trap_vec == (exc_strobe & word[TRAP_LSB +: EXC_N])); // R6
   end

endmodule

bind fp_status_ctrl fpsc_checker #(
   .WORD_W(WORD_W), .EXC_N(EXC_N), .STICKY_LSB(STICKY_LSB), .TRAP_LSB(TRAP_LSB),
   .VEC_M(VEC_M), .DEF_M(DEF_M), .REG_TRAP(REG_TRAP)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .upd_valid  (upd_valid),
   .vec_load   (vec_load),
   .exc_strobe (exc_strobe),
   .trap_vec   (trap_vec),
   .word       (word_q)
);

// File: tb/fp_status_ctrl_test.sv
`timescale 1ns/1ps
module fp_status_ctrl_test;

   localparam logic [31:0] WMASK = 32'h09C0_1F1F;
   localparam logic [31:0] VMASK = 32'h0037_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        upd_valid = 1'b0;
   logic [31:0] upd_mask = '0;
   logic [31:0] upd_flags = '0;
   logic [31:0] prev_word;
   logic        vec_load = 1'b0;
   logic [4:0]  vec_data = '0;
   logic [4:0]  exc_strobe = '0;
   logic        sat_strobe = 1'b0;
   logic        trap_req;
   logic [4:0]  trap_vec;
   logic [1:0]  round_mode;
   logic        flush_zero;

   int n_chk = 0;
   int n_fail = 0;
   logic [31:0] exp_w = '0;

   always #10 clk = ~clk;   // 50 MHz

   fp_status_ctrl uut (
      .clk(clk), .rst_n(rst_n),
      .upd_valid(upd_valid), .upd_mask(upd_mask), .upd_flags(upd_flags),
      .prev_word(prev_word),
      .vec_load(vec_load), .vec_data(vec_data),
      .exc_strobe(exc_strobe), .sat_strobe(sat_strobe),
      .trap_req(trap_req), .trap_vec(trap_vec),
      .round_mode(round_mode), .flush_zero(flush_zero)
   );

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", what, act, exp);
      end
   endtask

   // one cycle of stimulus, entered and left at a falling edge
   task automatic step(input string tag, input bit uv, input logic [31:0] m,
                       input logic [31:0] f, input logic [4:0] exc, input bit sat,
                       input bit vl, input logic [4:0] vd);
      logic [31:0] nw;
      logic [4:0]  tr;
      nw = exp_w;
      tr = exc & exp_w[12:8];
      if (uv) nw = (((exp_w & ~m) ^ f) & WMASK) | (exp_w & ~WMASK);
      if (vl) begin
         nw = nw & ~VMASK;
         nw[18:16] = vd[2:0];
         nw[21:20] = vd[4:3];
      end
      nw[4:0] = nw[4:0] | (exc & ~exp_w[12:8]);
      if (sat) nw[27] = 1'b1;
      upd_valid = uv; upd_mask = m; upd_flags = f;
      exc_strobe = exc; sat_strobe = sat; vec_load = vl; vec_data = vd;
      #1;
      if (uv) chk({tag, " R3 prior word"}, prev_word, exp_w);
      @(posedge clk);
      @(negedge clk);
      upd_valid = 1'b0; upd_mask = '0; upd_flags = '0;
      exc_strobe = '0; sat_strobe = 1'b0; vec_load = 1'b0; vec_data = '0;
      exp_w = nw;
      chk({tag, " word"}, prev_word, nw);
      chk({tag, " trap_vec"}, {27'd0, trap_vec}, {27'd0, tr});
      chk({tag, " trap_req"}, {31'd0, trap_req}, {31'd0, |tr});
   endtask

   task automatic upd(input string tag, input logic [31:0] m, input logic [31:0] f);
      step(tag, 1'b1, m, f, 5'd0, 1'b0, 1'b0, 5'd0);
   endtask

   task automatic idle(input string tag);
      step(tag, 1'b0, '0, '0, 5'd0, 1'b0, 1'b0, 5'd0);
   endtask

   task automatic t_reset;
      chk("R1 word", prev_word, 32'd0);
      chk("R1 trap_req", {31'd0, trap_req}, 32'd0);
      chk("R1 trap_vec", {27'd0, trap_vec}, 32'd0);
      chk("R1 round_mode", {30'd0, round_mode}, 32'd0);
      chk("R1 flush_zero", {31'd0, flush_zero}, 32'd0);
   endtask

   task automatic t_rule;
      upd("R2 preset", 32'hFFFF_FFFF, 32'h0000_000F);
      chk("R2 preset value", prev_word, 32'h0000_000F);
      // bit0 keep, bit1 toggle, bit2 clear, bit3 set
      upd("R2 four cases", 32'h0000_000C, 32'h0000_000A);
      chk("R2 four cases value", prev_word, 32'h0000_0009);
      upd("R2 clear all", 32'hFFFF_FFFF, 32'h0);
   endtask

   task automatic t_protect;
      step("R9 load", 1'b0, '0, '0, 5'd0, 1'b0, 1'b1, 5'b10101);
      chk("R9 vector bits", prev_word & VMASK, 32'h0021_0000 | 32'h0005_0000);
      upd("R4 toggle all", 32'h0, 32'hFFFF_FFFF);
      chk("R4 reserved zero", prev_word & ~(WMASK | VMASK), 32'd0);
      upd("R4 clear all", 32'hFFFF_FFFF, 32'h0);
      chk("R4 vector kept", prev_word, 32'h0025_0000);
      step("R9 reload", 1'b0, '0, '0, 5'd0, 1'b0, 1'b1, 5'b01010);
   endtask

   task automatic t_round;
      for (int i = 0; i < 4; i++) begin
         upd("R7 mode", 32'h00C0_0000, 32'(i) << 22);
         chk("R7 round_mode", {30'd0, round_mode}, 32'(i));
      end
      upd("R7 fz on", 32'h0100_0000, 32'h0100_0000);
      chk("R7 flush_zero on", {31'd0, flush_zero}, 32'd1);
      upd("R7 fz toggle", 32'h0, 32'h0100_0000);
      chk("R7 flush_zero off", {31'd0, flush_zero}, 32'd0);
   endtask

   task automatic t_sticky;
      upd("R5 untrap", 32'h0000_1F1F, 32'h0);
      for (int i = 0; i < 5; i++) begin
         step("R5 strobe", 1'b0, '0, '0, 5'(1 << i), 1'b0, 1'b0, 5'd0);
         chk("R5 sticky bit", {31'd0, prev_word[i]}, 32'd1);
      end
      idle("R5 hold a");
      idle("R5 hold b");
      chk("R5 sticky held", {27'd0, prev_word[4:0]}, 32'h1F);
      upd("R5 sw clear underflow", 32'h0000_0008, 32'h0);
      chk("R5 underflow cleared", {27'd0, prev_word[4:0]}, 32'h17);
   endtask

   task automatic t_trap;
      upd("R6 setup", 32'h0000_1F1F, 32'h0000_0200);  // trap divide-by-zero only
      step("R6 strobe", 1'b0, '0, '0, 5'b00011, 1'b0, 1'b0, 5'd0);
      chk("R6 trap_vec", {27'd0, trap_vec}, 32'h02);
      chk("R6 sticky", {27'd0, prev_word[4:0]}, 32'h01);
      idle("R6 pulse end");
      chk("R6 trap_req low", {31'd0, trap_req}, 32'd0);
      step("R6 all", 1'b0, '0, '0, 5'b11111, 1'b0, 1'b0, 5'd0);
      idle("R6 idle");
   endtask

   task automatic t_sat;
      step("R8 strobe", 1'b0, '0, '0, 5'd0, 1'b1, 1'b0, 5'd0);
      chk("R8 bit27", {31'd0, prev_word[27]}, 32'd1);
      idle("R8 hold");
      upd("R8 clear", 32'h0800_0000, 32'h0);
      chk("R8 cleared", {31'd0, prev_word[27]}, 32'd0);
   endtask

   task automatic t_collide;
      upd("R10 setup", 32'h0000_1F1F, 32'h0);
      step("R10 clear vs strobe", 1'b1, 32'h0000_001F, 32'h0, 5'b00100, 1'b0, 1'b0, 5'd0);
      chk("R10 strobe survives", {27'd0, prev_word[4:0]}, 32'h04);
      // enable underflow trap in the same cycle as an underflow strobe
      step("R10 old enable", 1'b1, 32'h0000_0800, 32'h0000_0800, 5'b01000, 1'b0, 1'b0, 5'd0);
      chk("R10 sticky set", {31'd0, prev_word[3]}, 32'd1);
      chk("R10 no trap", {31'd0, trap_req}, 32'd0);
      step("R10 now trapped", 1'b0, '0, '0, 5'b01000, 1'b0, 1'b0, 5'd0);
      chk("R10 trap", {27'd0, trap_vec}, 32'h08);
   endtask

   bit done = 1'b0;

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_rule();
      t_protect();
      t_round();
      t_sticky();
      t_trap();
      t_sat();
      t_collide();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule